// File: doc/BRIEF.md
# Processor Trap Dispatcher

This unit sits next to a processor pipeline and decides, one cycle at a time, whether and how a trap is taken. It accepts three kinds of trap: a synchronous exception with a cause code and an optional faulting address, a level-prioritised interrupt, and a debug event. For each accepted trap it commits every special-register update in a single clock edge. Those registers are the status word, the per-level exception PCs and saved status words, the double-exception PC, the cause and faulting-address registers, and the debug cause register. In the cycle after the request it issues a one-cycle redirect strobe together with the target PC.

A level-1 interrupt is folded into the general exception path: it carries a fixed cause code and is steered to the user, kernel or double vector. An interrupt at a level above one, and any debug event, instead saves the PC and status word into registers owned by that level, raises the status interrupt level and jumps to a per-level vector. Vector targets may be relocated through a writable vector-base register. A wait operation lowers the interrupt level and halts the core until an interrupt qualifies.

The status word holds the interrupt level in bits [3:0], the exception-mode flag in bit 4 and the user-mode flag in bit 5. The effective interrupt level is the status field, raised to at least `EXCM_LEVEL` while exception mode is set. Vector offsets from the base are 0x300 for kernel, 0x340 for user and 0x3C0 for double; level L (L ≥ 2) uses 0x180 + 0x40·(L−2). The debug event uses the level `DEBUG_LEVEL`.

Top module: `trap_dispatch`

## Requirements
- R1: An exception taken with exception mode clear stores the PC in the level-1 exception PC, writes the cause code, sets status bit 4, and targets the user vector (offset 0x340) when status bit 5 is set or the kernel vector (offset 0x300) when it is clear.
- R2: An exception taken with status bit 4 set targets the double vector (offset 0x3C0), stores the PC in the double-exception PC when `HAS_DEPC` is 1, and leaves the level-1 exception PC unchanged.
- R3: An exception flagged as carrying an address writes that address into the faulting-address register; an exception without the flag leaves that register unchanged.
- R4: A qualifying interrupt at level L > 1 stores the PC in the level-L exception PC and the prior status word in the level-L saved status. It then sets status bits [3:0] to L, sets bit 4, and targets the level-L vector.
- R5: An interrupt is taken only if its level exceeds the effective interrupt level, is at most `NUM_LEVELS`, and at least one of its sources is both pending and enabled; otherwise the state is unchanged and there is no redirect.
- R6: A qualifying level-1 interrupt writes cause code `L1_CAUSE` (4) and follows the R1/R2 user, kernel and double routing.
- R7: When several levels qualify, only the highest one is taken; a synchronous exception in the same cycle is taken instead of any interrupt.
- R8: A debug event is taken only when the effective level is below `DEBUG_LEVEL`. It writes the debug cause, saves the PC and status word into the debug level's registers, sets status bits [3:0] to `DEBUG_LEVEL`, sets bit 4, and targets that level's vector. A rejected debug event changes nothing.
- R9: With relocation enabled, every target equals the current vector-base register plus the vector offset; the vector base resets to `RESET_VBASE` and is reloaded by a write.
- R10: A wait request writes its level into status bits [3:0] and raises `halted` unless an interrupt already qualifies at the new level. `halted` falls when an interrupt is taken.
- R11: `redirect` rises in the cycle after an accepted trap request, stays high for exactly one cycle, and comes with the target on `redirectPc`.
- R12: After reset the status word is 0, the vector base is `RESET_VBASE`, and `redirect` and `halted` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pc | input | XLEN | PC of the trapping or interrupted instruction |
| excReq | input | 1 | Synchronous exception request |
| excCause | input | CAUSE_W | Exception cause code |
| excHasAddr | input | 1 | Exception carries a faulting address |
| excAddr | input | XLEN | Faulting address |
| irqPending | input | NUM_IRQ | Pending interrupt sources |
| irqEnable | input | NUM_IRQ | Enabled interrupt sources |
| dbgReq | input | 1 | Debug event request |
| dbgCause | input | CAUSE_W | Debug cause code |
| waitReq | input | 1 | Wait-for-interrupt request |
| waitLevel | input | 4 | Level written by a wait |
| psWrEn | input | 1 | Core write of the status word |
| psWrData | input | XLEN | Status word write data |
| vbWrEn | input | 1 | Core write of the vector base |
| vbWrData | input | XLEN | Vector base write data |
| redirect | output | 1 | One-cycle redirect strobe |
| redirectPc | output | XLEN | Redirect target |
| halted | output | 1 | Core halted by a wait |
| psOut | output | XLEN | Status word |
| epcFlat | output | DEBUG_LEVEL*XLEN | Exception PCs, slot i-1 holds level i |
| epsFlat | output | (DEBUG_LEVEL-1)*XLEN | Saved status words, slot i-2 holds level i |
| depcOut | output | XLEN | Double-exception PC |
| causeOut | output | CAUSE_W | Exception cause register |
| vaddrOut | output | XLEN | Faulting-address register |
| dbgCauseOut | output | CAUSE_W | Debug cause register |
| vecBaseOut | output | XLEN | Vector base register |

## Verification
The assertions assume that the core raises each trap request as a single-cycle pulse and leaves at least one idle cycle between two accepted requests. With that spacing the one-cycle redirect and the level rise after a take are properties of the design, not of a held input. They also assume `NUM_LEVELS` is below `DEBUG_LEVEL`, so that every interrupt level has its own save registers. The stimulus pulses each request for exactly one cycle, then clears it and waits before the next. It writes the status word only in cycles with no trap, and it removes pending interrupt bits after the trap they were meant to cause.

// File: rtl/trapPkg.sv
package trapPkg;
  localparam int LVL_W   = 4;
  localparam int PS_EXCM = 4;
  localparam int PS_UM   = 5;

  typedef struct packed {
    logic             takeExc;
    logic             takeDbg;
    logic             takeIrq;
    logic             takeWait;
    logic             generalRoute;
    logic             isDouble;
    logic             toUser;
    logic             writeVaddr;
    logic [LVL_W-1:0] level;
  } trapCtl_t;
endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trapPkg::*;
#(
  parameter int NUM_IRQ     = 8,
  parameter int NUM_LEVELS  = 5,
  parameter logic [4*NUM_IRQ-1:0] IRQ_LEVELS = 32'h6354_3211,
  parameter int EXCM_LEVEL  = 3,
  parameter int DEBUG_LEVEL = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               excReq,
  input  logic               excHasAddr,
  input  logic               dbgReq,
  input  logic               waitReq,
  input  logic [LVL_W-1:0]   waitLevel,
  input  logic [NUM_IRQ-1:0] irqPending,
  input  logic [NUM_IRQ-1:0] irqEnable,
  input  logic [LVL_W-1:0]   psLevel,
  input  logic               psExcm,
  input  logic               psUm,
  output trapCtl_t           ctl,
  output logic               halted
);
  localparam logic [LVL_W-1:0] EXCM_L = LVL_W'(EXCM_LEVEL);
  localparam logic [LVL_W-1:0] DBG_L  = LVL_W'(DEBUG_LEVEL);
  localparam logic [LVL_W-1:0] ONE_L  = LVL_W'(1);

  function automatic logic [NUM_IRQ-1:0] maskFor(int lv);
    logic [NUM_IRQ-1:0] m;
    for (int i = 0; i < NUM_IRQ; i++)
      m[i] = (IRQ_LEVELS[4*i +: 4] == 4'(lv));
    return m;
  endfunction

  function automatic logic [LVL_W-1:0] raiseLvl(logic [LVL_W-1:0] l, logic excm);
    return (excm && l < EXCM_L) ? EXCM_L : l;
  endfunction

  logic [NUM_LEVELS:1] levelHit;
  logic [LVL_W-1:0]    bestLevel;
  logic [LVL_W-1:0]    curLevel;
  logic [LVL_W-1:0]    waitCur;
  logic                dbgOk;
  logic                irqOk;

  generate
    for (genvar lv = 1; lv <= NUM_LEVELS; lv++) begin : g_lvl
      localparam logic [NUM_IRQ-1:0] LV_MASK = maskFor(lv);
      assign levelHit[lv] = |(irqPending & irqEnable & LV_MASK);
    end
  endgenerate

  always_comb begin
    bestLevel = '0;
    for (int lv = 1; lv <= NUM_LEVELS; lv++)
      if (levelHit[lv]) bestLevel = LVL_W'(lv);
  end

  assign curLevel = raiseLvl(psLevel, psExcm);
  assign waitCur  = raiseLvl(waitLevel, psExcm);
  assign dbgOk    = dbgReq && (curLevel < DBG_L);
  assign irqOk    = bestLevel > curLevel;

  always_comb begin
    ctl              = '0;
    ctl.takeExc      = excReq;
    ctl.takeDbg      = !excReq && dbgOk;
    ctl.takeIrq      = !excReq && !dbgOk && irqOk;
    ctl.takeWait     = waitReq && !excReq && !dbgOk && !irqOk;
    ctl.generalRoute = excReq || (ctl.takeIrq && bestLevel == ONE_L);
    ctl.isDouble     = psExcm;
    ctl.toUser       = psUm;
    ctl.writeVaddr   = excReq && excHasAddr;
    ctl.level        = ctl.takeDbg ? DBG_L : bestLevel;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      halted <= 1'b0;
    else if (ctl.takeExc || ctl.takeDbg || ctl.takeIrq)
      halted <= 1'b0;
    else if (ctl.takeWait)
      halted <= !(bestLevel > waitCur);
  end

  // R5
  irq_above_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.takeIrq |-> (ctl.level > curLevel && ctl.level <= LVL_W'(NUM_LEVELS)));

  // R7
  single_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.takeExc, ctl.takeDbg, ctl.takeIrq, ctl.takeWait}));

  // R10
  halt_after_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(halted) |-> $past(waitReq));
endmodule

// File: rtl/trap_regs.sv
module trap_regs
  import trapPkg::*;
#(
  parameter int XLEN        = 32,
  parameter int CAUSE_W     = 6,
  parameter int DEBUG_LEVEL = 6,
  parameter bit HAS_DEPC    = 1'b1,
  parameter bit RELOC_EN    = 1'b1,
  parameter logic [XLEN-1:0] RESET_VBASE = 32'h4000_0000,
  parameter int KERNEL_OFF  = 'h300,
  parameter int USER_OFF    = 'h340,
  parameter int DOUBLE_OFF  = 'h3C0,
  parameter int LEVEL_OFF   = 'h180,
  parameter int LEVEL_STEP  = 'h40,
  parameter int L1_CAUSE    = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  trapCtl_t                      ctl,
  input  logic [XLEN-1:0]               pc,
  input  logic [CAUSE_W-1:0]            excCause,
  input  logic [XLEN-1:0]               excAddr,
  input  logic [CAUSE_W-1:0]            dbgCause,
  input  logic [LVL_W-1:0]              waitLevel,
  input  logic                          psWrEn,
  input  logic [XLEN-1:0]               psWrData,
  input  logic                          vbWrEn,
  input  logic [XLEN-1:0]               vbWrData,
  output logic [XLEN-1:0]               ps,
  output logic [DEBUG_LEVEL*XLEN-1:0]   epcFlat,
  output logic [(DEBUG_LEVEL-1)*XLEN-1:0] epsFlat,
  output logic [XLEN-1:0]               depc,
  output logic [CAUSE_W-1:0]            cause,
  output logic [XLEN-1:0]               vaddr,
  output logic [CAUSE_W-1:0]            dbgCauseR,
  output logic [XLEN-1:0]               vecBase,
  output logic                          redirect,
  output logic [XLEN-1:0]               redirectPc
);
  localparam logic [XLEN-1:0] KERNEL_W = XLEN'(KERNEL_OFF);
  localparam logic [XLEN-1:0] USER_W   = XLEN'(USER_OFF);
  localparam logic [XLEN-1:0] DOUBLE_W = XLEN'(DOUBLE_OFF);
  localparam logic [XLEN-1:0] LVLOFF_W = XLEN'(LEVEL_OFF);
  localparam logic [XLEN-1:0] STEP_W   = XLEN'(LEVEL_STEP);
  localparam logic [CAUSE_W-1:0] L1C   = CAUSE_W'(L1_CAUSE);

  logic [XLEN-1:0] epc [1:DEBUG_LEVEL];
  logic [XLEN-1:0] eps [2:DEBUG_LEVEL];
  logic [XLEN-1:0] offset;
  logic [XLEN-1:0] target;
  logic            anyTake;

  assign anyTake = ctl.takeExc || ctl.takeDbg || ctl.takeIrq;

  always_comb begin
    if (ctl.generalRoute)
      offset = ctl.isDouble ? DOUBLE_W : (ctl.toUser ? USER_W : KERNEL_W);
    else
      offset = LVLOFF_W + (XLEN'(ctl.level) - XLEN'(2)) * STEP_W;
  end

  generate
    if (RELOC_EN) begin : g_reloc
      assign target = vecBase + offset;
    end else begin : g_fixed
      assign target = RESET_VBASE + offset;
    end
    for (genvar i = 1; i <= DEBUG_LEVEL; i++) begin : g_epc
      assign epcFlat[(i-1)*XLEN +: XLEN] = epc[i];
    end
    for (genvar i = 2; i <= DEBUG_LEVEL; i++) begin : g_eps
      assign epsFlat[(i-2)*XLEN +: XLEN] = eps[i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ps         <= '0;
      depc       <= '0;
      cause      <= '0;
      vaddr      <= '0;
      dbgCauseR  <= '0;
      vecBase    <= RESET_VBASE;
      redirect   <= 1'b0;
      redirectPc <= '0;
      for (int i = 1; i <= DEBUG_LEVEL; i++) epc[i] <= '0;
      for (int i = 2; i <= DEBUG_LEVEL; i++) eps[i] <= '0;
    end else begin
      redirect <= anyTake;
      if (anyTake) redirectPc <= target;
      if (ctl.generalRoute) begin
        ps[PS_EXCM] <= 1'b1;
        cause       <= ctl.takeExc ? excCause : L1C;
        if (ctl.isDouble && HAS_DEPC) depc <= pc;
        else epc[1] <= pc;
      end else if (ctl.takeIrq || ctl.takeDbg) begin
        ps[LVL_W-1:0] <= ctl.level;
        ps[PS_EXCM]   <= 1'b1;
        for (int i = 2; i <= DEBUG_LEVEL; i++) begin
          if (LVL_W'(i) == ctl.level) begin
            epc[i] <= pc;
            eps[i] <= ps;
          end
        end
      end else if (ctl.takeWait) begin
        ps[LVL_W-1:0] <= waitLevel;
      end else if (psWrEn) begin
        ps <= psWrData;
      end
      if (ctl.takeDbg)    dbgCauseR <= dbgCause;
      if (ctl.writeVaddr) vaddr     <= excAddr;
      if (vbWrEn)         vecBase   <= vbWrData;
    end
  end

  // R11
  redirect_excm_chk: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> ps[PS_EXCM]);

  // R4
  level_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.takeIrq && !ctl.generalRoute) |=> ps[LVL_W-1:0] == $past(ctl.level));

  // R2
  double_keeps_epc1_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.generalRoute && ctl.isDouble && HAS_DEPC) |=> epc[1] == $past(epc[1]));

  // R3
  vaddr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.writeVaddr |=> $stable(vaddr));
endmodule

// File: rtl/trap_dispatch.sv
module trap_dispatch
  import trapPkg::*;
#(
  parameter int XLEN        = 32,
  parameter int CAUSE_W     = 6,
  parameter int NUM_IRQ     = 8,
  parameter int NUM_LEVELS  = 5,
  parameter logic [4*NUM_IRQ-1:0] IRQ_LEVELS = 32'h6354_3211,
  parameter int EXCM_LEVEL  = 3,
  parameter int DEBUG_LEVEL = 6,
  parameter bit HAS_DEPC    = 1'b1,
  parameter bit RELOC_EN    = 1'b1,
  parameter logic [XLEN-1:0] RESET_VBASE = 32'h4000_0000,
  parameter int L1_CAUSE    = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [XLEN-1:0]                 pc,
  input  logic                            excReq,
  input  logic [CAUSE_W-1:0]              excCause,
  input  logic                            excHasAddr,
  input  logic [XLEN-1:0]                 excAddr,
  input  logic [NUM_IRQ-1:0]              irqPending,
  input  logic [NUM_IRQ-1:0]              irqEnable,
  input  logic                            dbgReq,
  input  logic [CAUSE_W-1:0]              dbgCause,
  input  logic                            waitReq,
  input  logic [3:0]                      waitLevel,
  input  logic                            psWrEn,
  input  logic [XLEN-1:0]                 psWrData,
  input  logic                            vbWrEn,
  input  logic [XLEN-1:0]                 vbWrData,
  output logic                            redirect,
  output logic [XLEN-1:0]                 redirectPc,
  output logic                            halted,
  output logic [XLEN-1:0]                 psOut,
  output logic [DEBUG_LEVEL*XLEN-1:0]     epcFlat,
  output logic [(DEBUG_LEVEL-1)*XLEN-1:0] epsFlat,
  output logic [XLEN-1:0]                 depcOut,
  output logic [CAUSE_W-1:0]              causeOut,
  output logic [XLEN-1:0]                 vaddrOut,
  output logic [CAUSE_W-1:0]              dbgCauseOut,
  output logic [XLEN-1:0]                 vecBaseOut
);
  trapCtl_t ctl;

  trap_ctrl #(
    .NUM_IRQ(NUM_IRQ), .NUM_LEVELS(NUM_LEVELS), .IRQ_LEVELS(IRQ_LEVELS),
    .EXCM_LEVEL(EXCM_LEVEL), .DEBUG_LEVEL(DEBUG_LEVEL)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .excReq(excReq), .excHasAddr(excHasAddr),
    .dbgReq(dbgReq), .waitReq(waitReq), .waitLevel(waitLevel),
    .irqPending(irqPending), .irqEnable(irqEnable),
    .psLevel(psOut[LVL_W-1:0]), .psExcm(psOut[PS_EXCM]), .psUm(psOut[PS_UM]),
    .ctl(ctl), .halted(halted)
  );

  trap_regs #(
    .XLEN(XLEN), .CAUSE_W(CAUSE_W), .DEBUG_LEVEL(DEBUG_LEVEL),
    .HAS_DEPC(HAS_DEPC), .RELOC_EN(RELOC_EN), .RESET_VBASE(RESET_VBASE),
    .L1_CAUSE(L1_CAUSE)
  ) uRegs (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pc(pc), .excCause(excCause),
    .excAddr(excAddr), .dbgCause(dbgCause), .waitLevel(waitLevel),
    .psWrEn(psWrEn), .psWrData(psWrData), .vbWrEn(vbWrEn), .vbWrData(vbWrData),
    .ps(psOut), .epcFlat(epcFlat), .epsFlat(epsFlat), .depc(depcOut),
    .cause(causeOut), .vaddr(vaddrOut), .dbgCauseR(dbgCauseOut),
    .vecBase(vecBaseOut), .redirect(redirect), .redirectPc(redirectPc)
  );

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !redirect);
endmodule

// File: tb/sim_trap_dispatch.sv
module sim_trap_dispatch;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] pc = '0, excAddr = '0, psWrData = '0, vbWrData = '0;
  logic        excReq = 0, excHasAddr = 0, dbgReq = 0, waitReq = 0, psWrEn = 0, vbWrEn = 0;
  logic [5:0]  excCause = '0, dbgCause = '0;
  logic [7:0]  irqPending = '0, irqEnable = '0;
  logic [3:0]  waitLevel = '0;
  logic        redirect, halted;
  logic [31:0] redirectPc, psOut, depcOut, vaddrOut, vecBaseOut;
  logic [191:0] epcFlat;
  logic [159:0] epsFlat;
  logic [5:0]  causeOut, dbgCauseOut;

  int nTests = 0, nFail = 0;
  bit done = 0, prevRedirect = 0;
  logic [31:0] expPc[$];
  string       expTag[$];

  always #2.5 clk = ~clk;

  trap_dispatch u0 (
    .clk(clk), .rstN(rstN), .pc(pc), .excReq(excReq), .excCause(excCause),
    .excHasAddr(excHasAddr), .excAddr(excAddr), .irqPending(irqPending),
    .irqEnable(irqEnable), .dbgReq(dbgReq), .dbgCause(dbgCause),
    .waitReq(waitReq), .waitLevel(waitLevel), .psWrEn(psWrEn), .psWrData(psWrData),
    .vbWrEn(vbWrEn), .vbWrData(vbWrData), .redirect(redirect), .redirectPc(redirectPc),
    .halted(halted), .psOut(psOut), .epcFlat(epcFlat), .epsFlat(epsFlat),
    .depcOut(depcOut), .causeOut(causeOut), .vaddrOut(vaddrOut),
    .dbgCauseOut(dbgCauseOut), .vecBaseOut(vecBaseOut)
  );

  function automatic logic [31:0] epcOf(int lv); return epcFlat[(lv-1)*32 +: 32]; endfunction
  function automatic logic [31:0] epsOf(int lv); return epsFlat[(lv-2)*32 +: 32]; endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask
  task automatic expectRedirect(input logic [31:0] p, input string t);
    expPc.push_back(p); expTag.push_back(t);
  endtask
  task automatic setPs(input logic [31:0] v);
    psWrEn = 1; psWrData = v; tick(); psWrEn = 0;
  endtask
  task automatic raiseExc(input logic [5:0] c, input bit hasA, input logic [31:0] a,
                          input logic [31:0] p, input logic [31:0] vec, input string t);
    excReq = 1; excCause = c; excHasAddr = hasA; excAddr = a; pc = p;
    expectRedirect(vec, t); tick(); excReq = 0; excHasAddr = 0;
  endtask

  // monitor: scoreboard of redirect targets, also R11 pulse width
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (redirect) begin
        if (prevRedirect) check("R11 redirect width", 32'd2, 32'd1);
        if (expPc.size() == 0) check("R5 unexpected redirect", redirectPc, 32'hFFFF_FFFF);
        else check({expTag.pop_front(), " target"}, redirectPc, expPc.pop_front());
      end
      prevRedirect = redirect;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; nTests++; nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R12 reset state
    check("R12 ps", psOut, 32'h0);
    check("R12 vecBase", vecBaseOut, 32'h4000_0000);
    check("R12 redirect", {31'b0, redirect}, 32'h0);
    check("R12 halted", {31'b0, halted}, 32'h0);
    rstN = 1; tick();

    // R1 kernel exception, R3 no address
    raiseExc(6'd7, 0, 32'h0, 32'h1000, 32'h4000_0300, "R1 kernel");
    check("R1 epc1", epcOf(1), 32'h1000);
    check("R1 cause", {26'b0, causeOut}, 32'd7);
    check("R1 ps", psOut, 32'h10);
    check("R3 vaddr untouched", vaddrOut, 32'h0);
    tick();

    // R2 double exception with address (R3)
    raiseExc(6'd9, 1, 32'h000D_EAD0, 32'h2000, 32'h4000_03C0, "R2 double");
    check("R2 depc", depcOut, 32'h2000);
    check("R2 epc1 kept", epcOf(1), 32'h1000);
    check("R3 vaddr", vaddrOut, 32'h000D_EAD0);
    check("R2 cause", {26'b0, causeOut}, 32'd9);
    tick();

    // R1 user exception
    setPs(32'h20);
    raiseExc(6'd3, 0, 32'h0, 32'h3000, 32'h4000_0340, "R1 user");
    check("R1 user epc1", epcOf(1), 32'h3000);
    check("R1 user ps", psOut, 32'h30);
    tick();

    // R6 level-1 interrupt in user mode
    setPs(32'h20);
    irqPending = 8'h01; irqEnable = 8'h01; pc = 32'h4000;
    expectRedirect(32'h4000_0340, "R6 level1");
    tick(); irqPending = 0;
    check("R6 cause", {26'b0, causeOut}, 32'd4);
    check("R6 epc1", epcOf(1), 32'h4000);
    check("R6 ps", psOut, 32'h30);
    tick();

    // R5 excm raises level to 3: level-3 blocked, then R4 level-4 taken
    setPs(32'h10);
    irqPending = 8'h08; irqEnable = 8'h18; pc = 32'h5000;
    tick(); tick();
    check("R5 excm block epc3", epcOf(3), 32'h0);
    check("R5 excm block ps", psOut, 32'h10);
    irqPending = 8'h18;
    expectRedirect(32'h4000_0200, "R4 level4");
    tick(); irqPending = 0;
    check("R4 epc4", epcOf(4), 32'h5000);
    check("R4 eps4", epsOf(4), 32'h10);
    check("R4 ps", psOut, 32'h14);
    tick();

    // R5 disabled source and level above NUM_LEVELS
    setPs(32'h0);
    irqPending = 8'hA0; irqEnable = 8'h80;
    tick(); tick();
    check("R5 no take ps", psOut, 32'h0);
    irqPending = 0; irqEnable = 0;

    // R7 highest level wins
    irqPending = 8'h34; irqEnable = 8'hFF; pc = 32'h6000;
    expectRedirect(32'h4000_0240, "R7 highest");
    tick(); irqPending = 0;
    check("R7 ps", psOut, 32'h15);
    check("R7 epc5", epcOf(5), 32'h6000);
    check("R7 eps5", epsOf(5), 32'h0);
    tick();

    // R7 exception beats interrupt
    setPs(32'h0);
    irqPending = 8'h04;
    raiseExc(6'd2, 0, 32'h0, 32'h7000, 32'h4000_0300, "R7 exc wins");
    check("R7 exc cause", {26'b0, causeOut}, 32'd2);
    check("R7 exc epc1", epcOf(1), 32'h7000);
    check("R7 exc ps", psOut, 32'h10);
    tick(); irqPending = 0; irqEnable = 0;

    // R8 debug accepted then rejected
    setPs(32'h03);
    dbgReq = 1; dbgCause = 6'h11; pc = 32'h8000;
    expectRedirect(32'h4000_0280, "R8 debug");
    tick(); dbgReq = 0;
    check("R8 dbgCause", {26'b0, dbgCauseOut}, 32'h11);
    check("R8 epc6", epcOf(6), 32'h8000);
    check("R8 eps6", epsOf(6), 32'h03);
    check("R8 ps", psOut, 32'h16);
    tick();
    dbgReq = 1; dbgCause = 6'h22;
    tick(); dbgReq = 0; tick();
    check("R8 rejected dbgCause", {26'b0, dbgCauseOut}, 32'h11);
    check("R8 rejected ps", psOut, 32'h16);

    // R9 relocated vectors
    vbWrEn = 1; vbWrData = 32'h8000_0000; tick(); vbWrEn = 0;
    check("R9 vecBase", vecBaseOut, 32'h8000_0000);
    setPs(32'h0);
    raiseExc(6'd5, 0, 32'h0, 32'h9000, 32'h8000_0300, "R9 reloc");
    tick();

    // R10 wait halts, then wakes on interrupt
    setPs(32'h0);
    waitReq = 1; waitLevel = 4'd2; tick(); waitReq = 0;
    check("R10 wait level", psOut, 32'h2);
    check("R10 halted", {31'b0, halted}, 32'h1);
    tick();
    irqPending = 8'h10; irqEnable = 8'h10; pc = 32'hA000;
    expectRedirect(32'h8000_0200, "R10 wake");
    tick(); irqPending = 0;
    check("R10 woken", {31'b0, halted}, 32'h0);
    check("R10 epc4", epcOf(4), 32'hA000);
    tick();

    // R10 wait with a qualifying interrupt already pending
    setPs(32'h05);
    irqPending = 8'h08; irqEnable = 8'h08; pc = 32'hB000;
    waitReq = 1; waitLevel = 4'd1; tick(); waitReq = 0;
    check("R10 no halt", {31'b0, halted}, 32'h0);
    check("R10 level1", psOut, 32'h1);
    expectRedirect(32'h8000_01C0, "R10 pending");
    tick(); irqPending = 0;
    check("R10 epc3", epcOf(3), 32'hB000);
    tick(); tick();

    check("R11 missing redirects", expPc.size(), 32'd0);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule